// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a target on a two-wire serial bus (one clock line, one open-drain data line). It watches both lines with the system clock, so the serial clock is never used as a clock. It answers one 7-bit device address. Through it a bus master can write and read a sparse 256-location byte space of configuration registers. A write transaction carries a register pointer byte and then any number of data bytes. Every byte is committed at its own acknowledge, and the pointer steps by one after each data byte, wrapping from FFh to 00h.

Reads come in three kinds: a current-pointer read, a random read (a pointer write cut short by a repeated start), and a sequential read that continues while the master acknowledges. Only the windows 08h–1Bh and 40h–57h hold storage. Every other location reads back as zero and drops writes. Each committed write is also shown to the rest of the chip as a one-cycle strobe with its address and data.

The controller is one state machine. Its states and transitions are:
- IDLE goes to DEVADDR on a start.
- DEVADDR goes to DEV_ACK on a match, or to WAIT on a mismatch.
- DEV_ACK goes to REGADDR for a write, or to RDATA for a read.
- REGADDR goes to REG_ACK.
- REG_ACK goes to WDATA.
- WDATA goes to WDATA_ACK, and WDATA_ACK goes back to WDATA.
- RDATA goes to RD_ACK.
- RD_ACK goes back to RDATA when the master acknowledges, or to WAIT when it does not.

From any state, a start goes to DEVADDR and a stop goes to IDLE.

Top module: `cfgbus_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start from any state begins a new address byte, and a stop returns the slave to idle with SDA released. Bytes clocked without a start get no acknowledge.
- R2: The first byte after a start carries the device address in bits 7:1 and the direction in bit 0 (0 = write). The default device address is 69h. On a match the slave pulls SDA low for the ninth clock. On a mismatch it never drives SDA until the next start.
- R3: In a write, the byte after the address byte loads the pointer. Each further byte is acknowledged and committed at the SCL fall that begins its acknowledge. The commit gives a one-cycle wr_stb, with wr_addr equal to the pointer and wr_data equal to the byte.
- R4: The pointer steps by one after every data byte written or read, and wraps from FFh to 00h.
- R5: A repeated start right after the pointer byte stores nothing but keeps the new pointer value.
- R6: In a read, the slave sends the byte at the pointer MSB first. It changes SDA only while SCL is low, and drives only the zero bits.
- R7: During a read, a master acknowledge (SDA low on the ninth clock) continues with the next location. A missing acknowledge makes the slave release SDA and wait for the next start or stop.
- R8: A read that begins with no pointer byte returns the location one past the last one written or read.
- R9: Locations 08h–1Bh and 40h–57h hold data. All others read as 00h, produce no wr_stb and keep nothing.
- R10: SDA is released in every state except the three acknowledge states and the zero bits of RDATA.
- R11: After reset every register reads 00h, the pointer is 00h, SDA is released and wr_stb is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_drive_low | output | 1 | When high, the open-drain pad pulls SDA low |
| wr_stb | output | 1 | One-cycle pulse for each committed register write |
| wr_addr | output | 8 | Register address of the committed write |
| wr_data | output | 8 | Data byte of the committed write |

## Verification
Directed frames come first:
- Bytes clocked without a start and a frame with the wrong device address show that only a matching address is acknowledged.
- A single-byte write and a burst write show the commit and the pointer step.
- A burst that starts at FFh only reaches storage at 08h if the pointer wrapped.
- A write and a read across the 1Bh/1Ch edge and the 57h/58h edge separate mapped locations from unmapped ones.
- Random reads, current-pointer reads and sequential reads ended by a missing acknowledge cover the pointer rules on the read side.

A seeded random mix of burst writes into the mapped windows, each read back sequentially from its start, then compares every strobe and every returned byte with a bench memory model.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEV_ACK,
        ST_REGADDR,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_WAIT
    } cfg_state_e;

    // true when addr lies in [base, base+len)
    function automatic logic in_window(input logic [7:0] addr,
                                       input logic [7:0] base,
                                       input int         len);
        int a;
        int b;
        a = int'(addr);
        b = int'(base);
        return (a >= b) && (a < b + len);
    endfunction

endpackage

// File: rtl/cfgbus_sync.sv
module cfgbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] last;

    assign raw = {sda_in, scl_in};

    // one identical synchroniser chain per bus line
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe <= '1;
            end else begin
                pipe <= {pipe[STAGES-2:0], raw[g]};
            end
        end
        assign synced[g] = pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last <= '1;
        end else begin
            last <= synced;
        end
    end

    logic scl_s;
    logic scl_d;
    logic sda_d;

    assign scl_s    = synced[0];
    assign sda_s    = synced[1];
    assign scl_d    = last[0];
    assign sda_d    = last[1];

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfgbus_regfile.sv
module cfgbus_regfile
    import cfgbus_pkg::*;
#(
    parameter logic [7:0] W0_BASE = 8'h08,
    parameter int         W0_LEN  = 20,
    parameter logic [7:0] W1_BASE = 8'h40,
    parameter int         W1_LEN  = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] waddr,
    input  logic [7:0] wdata,
    input  logic [7:0] raddr,
    output logic [7:0] rdata,
    output logic       rhit
);

    localparam int TOTAL = W0_LEN + W1_LEN;
    localparam int IDX_W = $clog2(TOTAL);

    function automatic logic mapped(input logic [7:0] a);
        return in_window(a, W0_BASE, W0_LEN) || in_window(a, W1_BASE, W1_LEN);
    endfunction

    function automatic logic [IDX_W-1:0] slot(input logic [7:0] a);
        if (in_window(a, W0_BASE, W0_LEN)) begin
            return IDX_W'(int'(a) - int'(W0_BASE));
        end
        return IDX_W'(int'(a) - int'(W1_BASE) + W0_LEN);
    endfunction

    logic [BYTE_W-1:0] mem [TOTAL];
    logic              whit;

    assign whit = mapped(waddr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) begin
                mem[i] <= '0;
            end
        end else if (we && whit) begin
            mem[slot(waddr)] <= wdata;
        end
    end

    assign rhit  = mapped(raddr);
    assign rdata = rhit ? mem[slot(raddr)] : '0;

endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
    import cfgbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] W0_BASE     = 8'h08,
    parameter int         W0_LEN      = 20,
    parameter logic [7:0] W1_BASE     = 8'h40,
    parameter int         W1_LEN      = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_drive_low,
    output logic       wr_stb,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_p;
    logic stop_p;

    cfgbus_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    cfg_state_e        state_q;
    cfg_state_e        state_d;
    logic [CNT_W-1:0]  bitcnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [7:0]        ptr_q;
    logic              rw_q;
    logic              mack_q;
    logic [BYTE_W-1:0] rf_rdata;
    logic              rf_hit;
    logic              byte_full;

    assign byte_full = (bitcnt_q == FULL);

    cfgbus_regfile #(
        .W0_BASE(W0_BASE),
        .W0_LEN (W0_LEN),
        .W1_BASE(W1_BASE),
        .W1_LEN (W1_LEN)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_stb),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (ptr_q),
        .rdata (rf_rdata),
        .rhit  (rf_hit)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (start_p) begin
            state_d = ST_DEVADDR;
        end else if (stop_p) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_DEVADDR:
                    if (scl_fall && byte_full)
                        state_d = (shreg_q[7:1] == DEV_ADDR) ? ST_DEV_ACK : ST_WAIT;
                ST_DEV_ACK:
                    if (scl_fall)
                        state_d = rw_q ? ST_RDATA : ST_REGADDR;
                ST_REGADDR:
                    if (scl_fall && byte_full) state_d = ST_REG_ACK;
                ST_REG_ACK:
                    if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:
                    if (scl_fall && byte_full) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK:
                    if (scl_fall) state_d = ST_WDATA;
                ST_RDATA:
                    if (scl_fall && byte_full) state_d = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_fall) state_d = mack_q ? ST_RDATA : ST_WAIT;
                ST_WAIT: state_d = ST_WAIT;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            ptr_q    <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            state_q <= state_d;
            wr_stb  <= 1'b0;
            if (start_p || stop_p) begin
                bitcnt_q <= '0;
            end else begin
                unique case (state_q)
                    ST_DEVADDR, ST_REGADDR, ST_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                        if (scl_fall && byte_full) begin
                            bitcnt_q <= '0;
                            if (state_q == ST_DEVADDR) begin
                                rw_q <= shreg_q[0];
                            end else if (state_q == ST_REGADDR) begin
                                ptr_q <= shreg_q;
                            end else begin
                                wr_stb  <= rf_hit;
                                wr_addr <= ptr_q;
                                wr_data <= shreg_q;
                                ptr_q   <= ptr_q + 8'd1;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall && rw_q) begin
                            shreg_q <= rf_rdata;
                            ptr_q   <= ptr_q + 8'd1;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise && !byte_full) begin
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                        if (scl_fall && !byte_full) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
                        end
                        if (scl_fall && byte_full) begin
                            bitcnt_q <= '0;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_s;
                        end
                        if (scl_fall && mack_q) begin
                            shreg_q <= rf_rdata;
                            ptr_q   <= ptr_q + 8'd1;
                        end
                    end
                    ST_IDLE, ST_REG_ACK, ST_WDATA_ACK, ST_WAIT: begin
                        bitcnt_q <= bitcnt_q;
                    end
                    default: begin
                        bitcnt_q <= '0;
                    end
                endcase
            end
        end
    end

    // data-line drive
    always_comb begin
        unique case (state_q)
            ST_DEV_ACK, ST_REG_ACK, ST_WDATA_ACK: sda_drive_low = 1'b1;
            ST_RDATA:                             sda_drive_low = ~shreg_q[BYTE_W-1];
            default:                              sda_drive_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfgbus_slave_chk.sv
module cfgbus_slave_chk
    import cfgbus_pkg::*;
#(
    parameter logic [7:0] W0_BASE = 8'h08,
    parameter int         W0_LEN  = 20,
    parameter logic [7:0] W1_BASE = 8'h40,
    parameter int         W1_LEN  = 24
) (
    input logic       clk,
    input logic       rst_n,
    input cfg_state_e state_q,
    input logic [7:0] ptr_q,
    input logic       wr_stb,
    input logic [7:0] wr_addr,
    input logic       sda_drive_low,
    input logic       start_p,
    input logic       stop_p
);

    // R1
    start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> state_q == ST_DEVADDR);

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_p && !start_p) |=> (state_q == ST_IDLE && !sda_drive_low));

    // R2
    mismatch_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WAIT |-> !sda_drive_low);

    // R3
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R4
    strobe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ptr_q == wr_addr + 8'd1);

    // R9
    strobe_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (in_window(wr_addr, W0_BASE, W0_LEN) || in_window(wr_addr, W1_BASE, W1_LEN)));

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> !sda_drive_low);

endmodule

bind cfgbus_slave cfgbus_slave_chk #(
    .W0_BASE(W0_BASE),
    .W0_LEN (W0_LEN),
    .W1_BASE(W1_BASE),
    .W1_LEN (W1_LEN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_q       (state_q),
    .ptr_q         (ptr_q),
    .wr_stb        (wr_stb),
    .wr_addr       (wr_addr),
    .sda_drive_low (sda_drive_low),
    .start_p       (start_p),
    .stop_p        (stop_p)
);

// File: tb/cfgbus_slave_test.sv
module cfgbus_slave_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_drive_low;
    logic wr_stb;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;

    assign sda_bus = m_sda & ~sda_drive_low;

    cfgbus_slave uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (m_scl),
        .sda_in        (sda_bus),
        .sda_drive_low (sda_drive_low),
        .wr_stb        (wr_stb),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data)
    );

    localparam logic [7:0] DEV_W = 8'hD2;
    localparam logic [7:0] DEV_R = 8'hD3;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [256];
    logic [7:0] ptr_m = 8'h00;
    logic [7:0] wbuf [16];
    logic [7:0] log_a [1024];
    logic [7:0] log_d [1024];
    int log_n = 0;

    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            log_a[log_n] = wr_addr;
            log_d[log_n] = wr_data;
            log_n++;
        end
    end

    function automatic bit mapped_m(input logic [7:0] a);
        return (a >= 8'h08 && a <= 8'h1B) || (a >= 8'h40 && a <= 8'h57);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input bit b, output bit s);
        m_sda = b;
        waitc(8);
        m_scl = 1'b1;
        waitc(8);
        s = sda_bus;
        waitc(8);
        m_scl = 1'b0;
        waitc(8);
    endtask

    task automatic do_start();
        if (m_scl == 1'b0) begin
            m_sda = 1'b1;
            waitc(8);
            m_scl = 1'b1;
            waitc(16);
        end
        m_sda = 1'b0;
        waitc(16);
        m_scl = 1'b0;
        waitc(8);
    endtask

    task automatic do_stop();
        m_sda = 1'b0;
        waitc(8);
        m_scl = 1'b1;
        waitc(16);
        m_sda = 1'b1;
        waitc(16);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        bit s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_cycle(1'b1, s);
            d = {d[6:0], s};
        end
        bit_cycle(!mack, s);
    endtask

    // burst write of n bytes from wbuf at address a
    task automatic do_write(input logic [7:0] a, input int n, input string tag);
        bit ack;
        int k;
        k = log_n;
        do_start();
        send_byte(DEV_W, ack);
        chk(ack, "R2 address ack", ack, 1);
        send_byte(a, ack);
        chk(ack, "R3 pointer ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk(ack, "R3 data ack", ack, 1);
        end
        do_stop();
        chk(sda_drive_low == 1'b0, "R1 released after stop", sda_drive_low, 0);
        for (int i = 0; i < n; i++) begin
            logic [7:0] ad;
            ad = a + 8'(i);
            if (mapped_m(ad)) begin
                chk(k < log_n && log_a[k] == ad, {tag, " strobe address"}, log_a[k], ad);
                chk(k < log_n && log_d[k] == wbuf[i], {tag, " strobe data"}, log_d[k], wbuf[i]);
                model[ad] = wbuf[i];
                k++;
            end
        end
        chk(log_n == k, "R9 strobe count", log_n, k);
        ptr_m = a + 8'(n);
    endtask

    // pointer write, repeated start, then n-byte read
    task automatic do_read_rand(input logic [7:0] a, input int n, input string tag);
        bit ack;
        int k;
        logic [7:0] d;
        k = log_n;
        do_start();
        send_byte(DEV_W, ack);
        chk(ack, "R2 address ack", ack, 1);
        send_byte(a, ack);
        chk(ack, "R3 pointer ack", ack, 1);
        do_start();
        send_byte(DEV_R, ack);
        chk(ack, "R2 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(d == model[8'(a + 8'(i))], tag, d, model[8'(a + 8'(i))]);
        end
        chk(sda_drive_low == 1'b0, "R7 released after missing ack", sda_drive_low, 0);
        do_stop();
        chk(log_n == k, "R5 repeated start stores nothing", log_n, k);
        ptr_m = a + 8'(n);
    endtask

    task automatic do_read_cur(input int n);
        bit ack;
        logic [7:0] d;
        do_start();
        send_byte(DEV_R, ack);
        chk(ack, "R2 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, d);
            chk(d == model[ptr_m], "R8 current-pointer read", d, model[ptr_m]);
            ptr_m = ptr_m + 8'd1;
        end
        do_stop();
    endtask

    initial begin
        bit ack;
        int k;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) model[i] = 8'h00;

        waitc(5);
        chk(sda_drive_low == 1'b0, "R11 reset drive", sda_drive_low, 0);
        chk(wr_stb == 1'b0, "R11 reset strobe", wr_stb, 0);
        rst_n = 1'b1;
        waitc(5);

        // R11 storage cleared, pointer at 00h
        do_read_rand(8'h08, 2, "R11 reset contents");
        ptr_m = 8'h00;
        do_start();
        do_stop();

        // R1 bytes clocked without a start get no ack
        m_scl = 1'b0;
        waitc(8);
        send_byte(DEV_W, ack);
        chk(!ack, "R1 no ack without start", ack, 0);
        m_scl = 1'b1;
        waitc(8);
        do_stop();

        // R2 wrong device address
        k = log_n;
        do_start();
        send_byte(8'hA0, ack);
        chk(!ack, "R2 mismatch not acked", ack, 0);
        send_byte(8'h08, ack);
        chk(!ack, "R2 mismatch stays silent", ack, 0);
        do_stop();
        chk(log_n == k, "R2 mismatch writes nothing", log_n, k);

        // R3 R4 burst write
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
        do_write(8'h08, 3, "R3 R4 burst write");
        do_read_rand(8'h09, 2, "R6 random read");
        do_read_cur(1);

        // R9 window edges
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        do_write(8'h1A, 4, "R9 window edge write");
        do_read_rand(8'h19, 5, "R9 window edge read");
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        do_write(8'h57, 2, "R9 upper edge write");
        do_read_rand(8'h56, 3, "R9 upper edge read");
        wbuf[0] = 8'hEE;
        do_write(8'h20, 1, "R9 unmapped write");
        do_read_rand(8'h20, 1, "R9 unmapped reads zero");

        // R4 pointer wrap: tenth byte lands at 08h
        for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'hC0 + i);
        do_write(8'hFF, 10, "R4 wrap write");
        do_read_cur(2);

        // R7 sequential read through a master ack chain
        do_read_rand(8'h08, 6, "R7 sequential read");
        do_read_cur(3);

        // randomised writes and read-back
        for (int it = 0; it < 12; it++) begin
            logic [7:0] a;
            int n;
            if ($urandom % 2 == 0) a = 8'(8'h08 + ($urandom % 20));
            else                   a = 8'(8'h40 + ($urandom % 24));
            n = 1 + int'($urandom % 6);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(a, n, "R3 R4 random write");
            do_read_rand(a, n + 1, "R6 random read-back");
        end
        do_read_cur(2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule